// File: doc/BRIEF.md
# ECC-Protected Overlay SRAM Controller

This block fronts an 8 KB on-chip scratch memory built from 1024 words of 64 bits. It stores an 8-bit single-error-correct, double-error-detect check field beside every word. Requesters use a valid/ready handshake to issue reads and writes. Every read returns a whole 64-bit word one cycle after it is accepted. A write may cover a byte, a half-word, a word or the full double-word.

A 64-bit write goes straight into the array in the cycle it is accepted. A narrower write becomes an internal three-step sequence. The first step reads the target word. The second checks and corrects that word and merges the new bytes into it. The third writes the merged word back with freshly computed check bits. This sequence always finishes, even when its read finds an uncorrectable error, so the stored word and its check bits agree afterwards.

A single enable bit, held in a small control register, turns error checking and correction on. The enable comes up off after reset. Check bits are written whatever the enable says. Corrected and uncorrectable errors are reported as one-cycle pulses to an external error collector.

Top module: `ecc_overlay_ram`

## Requirements
- R1: After reset `reqReady` is high, `rspValid`, `eccSingle` and `eccDouble` are low, and checking is disabled, so a corrupted word reads back raw with no error pulse.
- R2: A read accepted at a clock edge (`reqValid` and `reqReady` high, `reqWrite` low) produces `rspValid` high for exactly the following cycle. In that cycle `rspData` holds the word at `reqAddr[12:3]`, including every earlier completed write.
- R3: The byte address splits as word index `reqAddr[12:3]` and byte offset `reqAddr[2:0]`. Byte k of a word is bits 8k+7..8k, and write bytes come from the same lanes of `reqWdata`. The size code is 0 for a byte, 1 for a half-word, 2 for a word and 3 for a double-word. A write of size s updates the 2^s bytes starting at the offset rounded down to a multiple of 2^s. All other bytes are left unchanged.
- R4: After a write with size code 0, 1 or 2 is accepted, `reqReady` is low for the next two cycles and high in the third. After a read or a size-3 write is accepted, `reqReady` stays high.
- R5: With checking enabled, a stored word with any one of its 72 bits flipped reads back corrected. `eccSingle` pulses in the `rspValid` cycle and `eccDouble` stays low.
- R6: With checking enabled, a stored word with two bits flipped raises `eccDouble` in the `rspValid` cycle and `eccSingle` stays low. The two pulses are never high together.
- R7: With checking disabled, `eccSingle` and `eccDouble` stay low and read data is returned uncorrected.
- R8: A partial write whose internal read finds two flipped bits raises `eccDouble` in the cycle after acceptance. It still writes the new bytes over the uncorrected old bytes with consistent check bits, so a later read returns that word with no error pulse.
- R9: A partial write whose internal read finds one flipped bit raises `eccSingle` in the cycle after acceptance and merges the new bytes into the corrected old word.
- R10: Check bits are written even while checking is disabled. Words written with checking off read back with no error pulse once checking is enabled.
- R11: The enable bit loads `ctlEccEn` at a clock edge where `ctlWrEn` is high, and keeps its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Load strobe for the check-enable register |
| ctlEccEn | input | 1 | Value loaded into the check-enable register |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqAddr | input | 13 | Byte address (word index in bits 12..3) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | Write size code: 0 byte, 1 half, 2 word, 3 double-word |
| reqWdata | input | 64 | Write data, lane-positioned |
| rspValid | output | 1 | Read data valid |
| rspData | output | 64 | Read data |
| eccSingle | output | 1 | One-cycle pulse: corrected single-bit error |
| eccDouble | output | 1 | One-cycle pulse: uncorrectable double-bit error |

## Verification
A wrong merge mask or a lost correction leaves no mark on the write itself. It only shows up as a wrong byte on the next read of that word, so every partial write in the sweeps is followed by a read of the same word. A sequencer stuck in or skipping a state appears within two cycles as a wrong `reqReady` level. A fault in the syndrome logic shows in the same cycle as the response: the wrong pulse fires, or a flipped bit survives in `rspData`, and sweeping every one of the 72 bit positions exposes any position that is mapped wrongly.

// File: rtl/eccram_pkg.sv
package eccram_pkg;

  localparam int DataW = 64;
  localparam int ChkW  = 8;
  localparam int CodeW = DataW + ChkW;
  localparam int LaneN = DataW / 8;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic accept;    // request taken this edge: capture array word and request
    logic wrFull;    // write full word from request bus this edge
    logic mergeCap;  // merge cycle of a partial write
    logic wrMerged;  // write back merged word this edge
    logic rspPhase;  // read response cycle
  } strobeT;

  typedef struct packed {
    logic [DataW-1:0] data;
    logic             single;
    logic             dbl;
  } decodeT;

  // XOR of Hamming positions of all set data bits (positions 3..71, powers of two skipped)
  function automatic logic [6:0] hamParity(logic [DataW-1:0] d);
    logic [6:0] c;
    logic [5:0] k;
    c = '0;
    k = '0;
    for (int p = 3; p < 72; p++) begin
      logic [6:0] pv;
      pv = 7'(p);
      if ((pv & (pv - 7'd1)) != 7'd0) begin
        if (d[k]) c = c ^ pv;
        k = k + 6'd1;
      end
    end
    return c;
  endfunction

  function automatic logic [CodeW-1:0] eccEncode(logic [DataW-1:0] d);
    logic [6:0] c;
    c = hamParity(d);
    return {(^d) ^ (^c), c, d};
  endfunction

  function automatic decodeT eccDecode(logic [CodeW-1:0] code, logic en);
    decodeT     r;
    logic [6:0] syn;
    logic       par;
    logic [5:0] k;
    r.data   = code[DataW-1:0];
    r.single = 1'b0;
    r.dbl    = 1'b0;
    syn      = hamParity(code[DataW-1:0]) ^ code[DataW+6:DataW];
    par      = ^code;
    if (en) begin
      if (par) begin
        r.single = 1'b1;
        k = '0;
        for (int p = 3; p < 72; p++) begin
          logic [6:0] pv;
          pv = 7'(p);
          if ((pv & (pv - 7'd1)) != 7'd0) begin
            if (pv == syn) r.data[k] = ~r.data[k];
            k = k + 6'd1;
          end
        end
      end else if (syn != 7'd0) begin
        r.dbl = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [LaneN-1:0] laneMask(logic [2:0] off, logic [1:0] sz);
    logic [LaneN-1:0] m;
    case (sz)
      2'd0:    m = 8'h01 << off;
      2'd1:    m = 8'h03 << {off[2:1], 1'b0};
      2'd2:    m = 8'h0F << {off[2], 2'b00};
      default: m = 8'hFF;
    endcase
    return m;
  endfunction

  function automatic logic [DataW-1:0] laneMerge(logic [DataW-1:0] oldD,
                                                 logic [DataW-1:0] newD,
                                                 logic [LaneN-1:0] m);
    logic [DataW-1:0] r;
    for (int i = 0; i < LaneN; i++)
      r[i*8 +: 8] = m[i] ? newD[i*8 +: 8] : oldD[i*8 +: 8];
    return r;
  endfunction

endpackage

// File: rtl/eccram_ctrl.sv
module eccram_ctrl
  import eccram_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlWrEn,
  input  logic       ctlEccEn,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [1:0] reqSize,
  output logic       reqReady,
  output logic       rspValid,
  output logic       eccOn,
  output strobeT     st
);

  typedef enum logic [1:0] {ST_IDLE, ST_MERGE, ST_WRITE} stateT;

  stateT state, stateNext;
  logic  accept, partial, rspValidQ, eccOnQ;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;
  assign partial  = reqWrite && (reqSize != 2'd3);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (accept && partial) stateNext = ST_MERGE;
      ST_MERGE: stateNext = ST_WRITE;
      ST_WRITE: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      rspValidQ <= 1'b0;
      eccOnQ    <= 1'b0;
    end else begin
      state     <= stateNext;
      rspValidQ <= accept && !reqWrite;
      if (ctlWrEn) eccOnQ <= ctlEccEn;
    end
  end

  always_comb begin
    st.accept   = accept;
    st.wrFull   = accept && reqWrite && !partial;
    st.mergeCap = (state == ST_MERGE);
    st.wrMerged = (state == ST_WRITE);
    st.rspPhase = rspValidQ;
  end

  assign rspValid = rspValidQ;
  assign eccOn    = eccOnQ;

endmodule

// File: rtl/eccram_dp.sv
module eccram_dp
  import eccram_pkg::*;
#(
  parameter int Words = 1024,
  localparam int WordAw = $clog2(Words),
  localparam int AddrW  = WordAw + 3
) (
  input  logic             clk,
  input  strobeT           st,
  input  logic             eccOn,
  input  logic [AddrW-1:0] reqAddr,
  input  logic [1:0]       reqSize,
  input  logic [DataW-1:0] reqWdata,
  output logic [DataW-1:0] rspData,
  output logic             errSingle,
  output logic             errDouble
);

  logic [CodeW-1:0]  memArray [Words];
  logic [CodeW-1:0]  rdWordQ;
  logic [WordAw-1:0] holdAddr;
  logic [LaneN-1:0]  holdMask;
  logic [DataW-1:0]  holdData;
  logic [DataW-1:0]  mergedQ;
  logic [WordAw-1:0] reqWord;
  decodeT            dec;

  assign reqWord = reqAddr[AddrW-1:3];

  always_ff @(posedge clk) begin
    if (st.wrFull)
      memArray[reqWord] <= eccEncode(reqWdata);
    else if (st.wrMerged)
      memArray[holdAddr] <= eccEncode(mergedQ);
  end

  always_ff @(posedge clk) begin
    if (st.accept) begin
      rdWordQ  <= memArray[reqWord];
      holdAddr <= reqWord;
      holdMask <= laneMask(reqAddr[2:0], reqSize);
      holdData <= reqWdata;
    end
    if (st.mergeCap)
      mergedQ <= laneMerge(dec.data, holdData, holdMask);
  end

  assign dec       = eccDecode(rdWordQ, eccOn);
  assign rspData   = dec.data;
  assign errSingle = (st.rspPhase || st.mergeCap) && dec.single;
  assign errDouble = (st.rspPhase || st.mergeCap) && dec.dbl;

endmodule

// File: rtl/ecc_overlay_ram.sv
module ecc_overlay_ram
  import eccram_pkg::*;
#(
  parameter int Words = 1024,
  localparam int AddrW = $clog2(Words) + 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrEn,
  input  logic             ctlEccEn,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [AddrW-1:0] reqAddr,
  input  logic             reqWrite,
  input  logic [1:0]       reqSize,
  input  logic [DataW-1:0] reqWdata,
  output logic             rspValid,
  output logic [DataW-1:0] rspData,
  output logic             eccSingle,
  output logic             eccDouble
);

  strobeT stW;
  logic   eccOnW;

  eccram_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctlWrEn  (ctlWrEn),
    .ctlEccEn (ctlEccEn),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqSize  (reqSize),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .eccOn    (eccOnW),
    .st       (stW)
  );

  eccram_dp #(.Words(Words)) u_dp (
    .clk       (clk),
    .st        (stW),
    .eccOn     (eccOnW),
    .reqAddr   (reqAddr),
    .reqSize   (reqSize),
    .reqWdata  (reqWdata),
    .rspData   (rspData),
    .errSingle (eccSingle),
    .errDouble (eccDouble)
  );

endmodule

// File: rtl/ecc_overlay_ram_chk.sv
module ecc_overlay_ram_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ctlWrEn,
  input logic       reqValid,
  input logic       reqReady,
  input logic       reqWrite,
  input logic [1:0] reqSize,
  input logic       rspValid,
  input logic       eccSingle,
  input logic       eccDouble,
  input logic       eccOnW
);

  // R4
  partial_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite && reqSize != 2'd3) |=> !reqReady ##1 !reqReady ##1 reqReady);

  // R4
  single_cycle_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (!reqWrite || reqSize == 2'd3)) |=> reqReady);

  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite) |=> rspValid);

  // R2
  rsp_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && reqReady && !reqWrite));

  // R7
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !eccOnW |-> (!eccSingle && !eccDouble));

  // R6
  err_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(eccSingle && eccDouble));

  // R8
  err_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eccSingle || eccDouble) |-> (rspValid || !reqReady));

  // R11
  en_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctlWrEn) |-> $stable(eccOnW));

endmodule

bind ecc_overlay_ram ecc_overlay_ram_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ctlWrEn   (ctlWrEn),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqWrite  (reqWrite),
  .reqSize   (reqSize),
  .rspValid  (rspValid),
  .eccSingle (eccSingle),
  .eccDouble (eccDouble),
  .eccOnW    (eccOnW)
);

// File: tb/ecc_overlay_ram_bench.sv
module ecc_overlay_ram_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlWrEn = 1'b0, ctlEccEn = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [12:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic [63:0] reqWdata = '0;
  logic        reqReady, rspValid, eccSingle, eccDouble;
  logic [63:0] rspData;

  int checks = 0, failures = 0;
  logic [63:0] model [16];

  always #2 clk = ~clk;

  ecc_overlay_ram u_ecc_overlay_ram (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlEccEn(ctlEccEn),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData),
    .eccSingle(eccSingle), .eccDouble(eccDouble)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic flipBit(input int w, input int b);
    u_ecc_overlay_ram.u_dp.memArray[w] = u_ecc_overlay_ram.u_dp.memArray[w] ^ (72'd1 << b);
  endtask

  task automatic setEcc(input logic en);
    @(negedge clk);
    ctlWrEn = 1'b1; ctlEccEn = en;
    @(negedge clk);
    ctlWrEn = 1'b0;
  endtask

  task automatic doRead(input int w, output logic [63:0] d, output logic s, output logic db, output logic v);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 13'(w * 8); reqSize = 2'd3;
    @(negedge clk);
    reqValid = 1'b0;
    d = rspData; s = eccSingle; db = eccDouble; v = rspValid;
  endtask

  // returns pulses seen in merge cycle and whether ready behaved
  task automatic doWrite(input int w, input int off, input logic [1:0] sz, input logic [63:0] data,
                         output logic s, output logic db, output logic rdyOk);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 13'(w * 8 + off); reqSize = sz; reqWdata = data;
    @(negedge clk);
    reqValid = 1'b0;
    s = eccSingle; db = eccDouble;
    if (sz == 2'd3) rdyOk = reqReady;
    else begin
      rdyOk = !reqReady;
      @(negedge clk);
      rdyOk = rdyOk && !reqReady && !eccSingle && !eccDouble;
      @(negedge clk);
      rdyOk = rdyOk && reqReady;
    end
  endtask

  function automatic logic [63:0] mergeExp(logic [63:0] oldD, logic [63:0] newD, int off, int sz);
    int n = 1 << sz;
    int base = (off / n) * n;
    logic [63:0] r = oldD;
    for (int i = 0; i < n; i++) r[(base + i) * 8 +: 8] = newD[(base + i) * 8 +: 8];
    return r;
  endfunction

  initial begin
    #600000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] d, e;
    logic s, db, v, ok;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !rspValid && !eccSingle && !eccDouble, "R1 reset outputs",
        {60'd0, reqReady, rspValid, eccSingle, eccDouble}, 64'h8);

    // full writes with checking off
    for (int w = 0; w < 16; w++) begin
      model[w] = 64'h0123_4567_89AB_CDEF * (w + 1) ^ (64'hF0F0 << w);
      doWrite(w, 0, 2'd3, model[w], s, db, ok);
      chk(ok, "R4 full write keeps ready", {63'd0, ok}, 64'd1);
    end
    for (int w = 0; w < 16; w++) begin
      doRead(w, d, s, db, v);
      chk(v && d == model[w], "R2 read after full write", d, model[w]);
    end

    // R1 / R7: checking off after reset, raw data returned
    flipBit(3, 5);
    doRead(3, d, s, db, v);
    e = model[3] ^ 64'h20;
    chk(d == e && !s && !db, "R1 R7 raw read when disabled", d, e);
    flipBit(3, 5);

    // R11: write strobe low keeps disabled
    @(negedge clk); ctlEccEn = 1'b1; @(negedge clk); ctlEccEn = 1'b0;
    flipBit(4, 9);
    doRead(4, d, s, db, v);
    chk(!s && d == (model[4] ^ 64'h200), "R11 enable unchanged without strobe", {63'd0, s}, 64'd0);
    flipBit(4, 9);

    setEcc(1'b1);
    // R10: words written while disabled are clean
    for (int w = 0; w < 16; w++) begin
      doRead(w, d, s, db, v);
      chk(d == model[w] && !s && !db, "R10 check bits written while disabled", d, model[w]);
    end

    // R3 / R4: partial write sweep, every size and offset
    for (int sz = 0; sz < 3; sz++) begin
      for (int off = 0; off < 8; off++) begin
        int w = (sz * 8 + off) % 16;
        logic [63:0] nd = {8{8'(8'h11 * (off + 1) + sz)}} ^ 64'hA5A5_0000_5A5A_FFFF;
        doWrite(w, off, 2'(sz), nd, s, db, ok);
        chk(ok && !s && !db, "R4 partial write ready low two cycles", {62'd0, s, db}, 64'd0);
        model[w] = mergeExp(model[w], nd, off, sz);
        doRead(w, d, s, db, v);
        chk(d == model[w] && !s && !db, "R3 partial write lanes", d, model[w]);
      end
    end

    // R5: every single-bit position corrected
    for (int b = 0; b < 72; b++) begin
      flipBit(5, b);
      doRead(5, d, s, db, v);
      chk(d == model[5] && s && !db, "R5 single-bit correction", d, model[5]);
      flipBit(5, b);
    end

    // R6: double-bit detection
    for (int b = 0; b < 72; b++) begin
      flipBit(6, b); flipBit(6, (b + 29) % 72);
      doRead(6, d, s, db, v);
      chk(db && !s && v, "R6 double-bit detect", {62'd0, s, db}, 64'd1);
      flipBit(6, b); flipBit(6, (b + 29) % 72);
    end

    // R8: partial write over double error still completes
    flipBit(7, 0); flipBit(7, 40);
    e = mergeExp(model[7] ^ 64'h0000_0100_0000_0001, 64'h0000_0000_00CC_0000, 2, 0);
    doWrite(7, 2, 2'd0, 64'h0000_0000_00CC_0000, s, db, ok);
    chk(db && !s && ok, "R8 double error in merge read reported", {62'd0, s, db}, 64'd1);
    model[7] = e;
    doRead(7, d, s, db, v);
    chk(d == e && !s && !db, "R8 write completes with consistent check bits", d, e);

    // R9: partial write over single error merges corrected data
    flipBit(8, 50);
    e = mergeExp(model[8], 64'h0000_0000_0000_BEEF, 0, 1);
    doWrite(8, 1, 2'd1, 64'h0000_0000_0000_BEEF, s, db, ok);
    chk(s && !db && ok, "R9 single error in merge read reported", {62'd0, s, db}, 64'd2);
    model[8] = e;
    doRead(8, d, s, db, v);
    chk(d == e && !s && !db, "R9 corrected word merged", d, e);

    // R7: disable again, double error passes raw and quiet
    setEcc(1'b0);
    flipBit(9, 3); flipBit(9, 60);
    e = model[9] ^ ((64'd1 << 3) | (64'd1 << 60));
    doRead(9, d, s, db, v);
    chk(d == e && !s && !db, "R7 disabled double error raw", d, e);
    flipBit(9, 3); flipBit(9, 60);

    // R11: strobe re-enables
    setEcc(1'b1);
    flipBit(10, 12);
    doRead(10, d, s, db, v);
    chk(s && d == model[10], "R11 enable loads on strobe", d, model[10]);
    flipBit(10, 12);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule